// File: doc/BRIEF.md
# Memory LCD Line-Update Engine

This block refreshes a one-bit-per-pixel memory-type LCD from a frame buffer held elsewhere on the chip. The buffer is a sequence of lines at a fixed byte stride. Each line has a run of pixel bytes and one flag byte, and bit 0 of the flag byte marks the line as dirty. Pixels are packed low bit first, so pixel x of a line sits in bit (x mod 8) of byte x/8.

A host strobe carries a two-bit command. Bit 0 asks for a refresh of only the dirty lines. Bit 1 asks for a refresh of every line, and in that case the flags are not consulted. The engine reads the buffer through a synchronous byte read port with one cycle of latency and never writes it. Clearing the flags is left to software. For each chosen line it shifts out a mode byte, the line number, the pixel bytes and a run of zero bits on a serial clock, data and chip-select interface. The bit rate comes from an 8-bit prescaler.

While an update runs, `busy` is high. When it ends, an optional one-cycle completion pulse fires. The defaults describe a 336 x 536 panel with a 44-byte line stride and the flag at byte 42.

Top module: `lcdline_top`

## Requirements
- R1: After reset busy, lcdCs, lcdSclk, lcdMosi and doneIrq are 0, and the prescaler holds 99, so the first update runs at one bit per 100 clock cycles.
- R2: A command with bit 1 set (cmdBits = 2'b10 or 2'b11) sends every line from line 0 upward, whatever the dirty flags hold.
- R3: A command of cmdBits = 2'b01 sends, in ascending order, only the lines whose byte at offset DIRTY_OFS from the line base (line × STRIDE) has bit 0 set.
- R4: Each sent line is sampled on rising lcdSclk edges in this order: MODE_BYTE with its MSB first; the line number counting from 1, as ADDR_BYTES bytes with the MSB first; the DATA_BYTES pixel bytes in rising address order, each with bit 0 first; then TRAILER_BYTES × 8 zero bits.
- R5: One serial bit lasts prescaler + 1 clock cycles, and a prescaler of 0 acts as 1. A value written through presWr takes effect from the next byte.
- R6: lcdCs rises with busy when a command is accepted, stays high for the whole update and falls one cycle before busy. lcdSclk pulses only while lcdCs is high.
- R7: busy goes high in the cycle after a command is accepted and stays high until the update is over. A command that arrives while busy is 1 is ignored.
- R8: When irqEnable is 1, doneIrq is high for exactly one cycle at the end of each update. When irqEnable is 0 it stays low.
- R9: A dirty-only update that finds no dirty line produces no lcdSclk pulse, and still ends with busy falling and the completion pulse.
- R10: A command strobe with cmdBits = 2'b00 is ignored: busy and lcdCs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdBits | input | 2 | Bit 0: dirty lines only; bit 1: all lines |
| presWr | input | 1 | Prescaler write strobe |
| presIn | input | 8 | New prescaler value |
| irqEnable | input | 1 | Enables the completion pulse |
| rdEn | output | 1 | Buffer read request |
| rdAddr | output | BUF_AW | Buffer byte address |
| rdData | input | 8 | Buffer byte, valid one cycle after rdEn |
| busy | output | 1 | High while an update is in progress |
| doneIrq | output | 1 | One-cycle completion pulse |
| lcdSclk | output | 1 | Serial clock |
| lcdMosi | output | 1 | Serial data, stable while lcdSclk is high |
| lcdCs | output | 1 | Active-high chip select for the panel |

## Verification
A corrupted line or byte counter shows up at once in the captured serial stream as a wrong line number, a shifted pixel byte or a missing trailer, and it shows within the first line it touches. A wrong flag decision shows as a missing or extra line frame. A wrong sequencer state shows as busy or lcdCs held too long or dropped early, or as a missing or doubled completion pulse. A divider fault shows on the second lcdSclk rise, because the spacing of the rises gives the bit period.

// File: rtl/lcdline_pkg.sv
package lcdline_pkg;

  typedef struct packed {
    logic       load;
    logic [7:0] loadByte;
  } dpStrobe_t;

  function automatic logic [7:0] reverse8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

endpackage

// File: rtl/lcdline_shift.sv
module lcdline_shift
  import lcdline_pkg::*;
#(
  parameter logic [7:0] DIV_RESET = 8'd99
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       presWr,
  input  logic [7:0] presIn,
  input  dpStrobe_t  strobe,
  output logic       sclk,
  output logic       mosi,
  output logic       byteDone
);

  logic [7:0] presReg;
  logic [7:0] curDiv;
  logic [7:0] divCnt;
  logic [2:0] bitCnt;
  logic [7:0] shReg;
  logic       active;
  logic [8:0] halfPoint;

  always_ff @(posedge clk) begin
    if (!rstN) presReg <= DIV_RESET;
    else if (presWr) presReg <= presIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curDiv   <= 8'd1;
      divCnt   <= '0;
      bitCnt   <= '0;
      shReg    <= '0;
      active   <= 1'b0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (strobe.load) begin
        curDiv <= (presReg == 8'd0) ? 8'd1 : presReg;
        shReg  <= strobe.loadByte;
        bitCnt <= '0;
        divCnt <= '0;
        active <= 1'b1;
      end else if (active) begin
        if (divCnt == curDiv) begin
          divCnt <= '0;
          if (bitCnt == 3'd7) begin
            active   <= 1'b0;
            byteDone <= 1'b1;
          end else begin
            bitCnt <= bitCnt + 3'd1;
            shReg  <= {1'b0, shReg[7:1]};
          end
        end else begin
          divCnt <= divCnt + 8'd1;
        end
      end
    end
  end

  assign halfPoint = ({1'b0, curDiv} + 9'd1) >> 1;
  assign sclk      = active && ({1'b0, divCnt} >= halfPoint);
  assign mosi      = active && shReg[0];

  // R4: data holds still while the serial clock is high
  a_r4_mosi_stable: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R5: divider count stays within the latched period
  a_r5_div_range: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (divCnt <= curDiv));

endmodule

// File: rtl/lcdline_ctrl.sv
module lcdline_ctrl
  import lcdline_pkg::*;
#(
  parameter int         NUM_LINES     = 536,
  parameter int         STRIDE        = 44,
  parameter int         DATA_BYTES    = 42,
  parameter int         DIRTY_OFS     = 42,
  parameter int         ADDR_BYTES    = 2,
  parameter int         TRAILER_BYTES = 2,
  parameter logic [7:0] MODE_BYTE     = 8'h80,
  parameter int         BUF_AW        = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdBits,
  input  logic              irqEnable,
  input  logic [7:0]        rdData,
  input  logic              byteDone,
  output logic              rdEn,
  output logic [BUF_AW-1:0] rdAddr,
  output dpStrobe_t         strobe,
  output logic              busy,
  output logic              csOut,
  output logic              doneIrq
);

  localparam int TOTAL_BYTES = 1 + ADDR_BYTES + DATA_BYTES + TRAILER_BYTES;
  localparam int BYTE_W      = $clog2(TOTAL_BYTES + 1);
  localparam int LINE_W      = $clog2(NUM_LINES + 1);
  localparam int FIELD_W     = 8 * ADDR_BYTES;
  localparam int DATA_LO     = 1 + ADDR_BYTES;
  localparam int DATA_HI     = DATA_LO + DATA_BYTES;

  typedef enum logic [2:0] {
    S_IDLE, S_FLAG_RD, S_FLAG_WAIT, S_BYTE_PREP,
    S_BYTE_WAIT, S_SHIFT, S_NEXT, S_FINISH
  } ctrlState_t;

  ctrlState_t        state;
  logic              allMode;
  logic [LINE_W-1:0] lineIdx;
  logic [BUF_AW-1:0] lineBase;
  logic [BYTE_W-1:0] byteIdx;
  logic              csReg;
  logic              isData;
  logic [FIELD_W-1:0] lineNum;
  logic [7:0]        constByte;
  logic [BUF_AW-1:0] dataOfs;

  assign isData  = (byteIdx >= BYTE_W'(DATA_LO)) && (byteIdx < BYTE_W'(DATA_HI));
  assign lineNum = FIELD_W'(lineIdx) + FIELD_W'(1);
  assign dataOfs = BUF_AW'(byteIdx - BYTE_W'(DATA_LO));

  // Header bytes are stored reversed so the LSB-first shifter sends them MSB first
  always_comb begin
    constByte = '0;
    if (byteIdx == '0) constByte = reverse8(MODE_BYTE);
    for (int k = 0; k < ADDR_BYTES; k++) begin
      if (byteIdx == BYTE_W'(k + 1))
        constByte = reverse8(lineNum[8*(ADDR_BYTES-1-k) +: 8]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      allMode  <= 1'b0;
      lineIdx  <= '0;
      lineBase <= '0;
      byteIdx  <= '0;
      csReg    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (cmdValid && (cmdBits != 2'b00)) begin
          allMode  <= cmdBits[1];
          lineIdx  <= '0;
          lineBase <= '0;
          csReg    <= 1'b1;
          state    <= S_FLAG_RD;
        end
        S_FLAG_RD: begin
          byteIdx <= '0;
          state   <= allMode ? S_BYTE_PREP : S_FLAG_WAIT;
        end
        S_FLAG_WAIT: state <= rdData[0] ? S_BYTE_PREP : S_NEXT;
        S_BYTE_PREP: state <= isData ? S_BYTE_WAIT : S_SHIFT;
        S_BYTE_WAIT: state <= S_SHIFT;
        S_SHIFT: if (byteDone) begin
          if (byteIdx == BYTE_W'(TOTAL_BYTES - 1)) state <= S_NEXT;
          else begin
            byteIdx <= byteIdx + BYTE_W'(1);
            state   <= S_BYTE_PREP;
          end
        end
        S_NEXT: begin
          if (lineIdx == LINE_W'(NUM_LINES - 1)) begin
            csReg <= 1'b0;
            state <= S_FINISH;
          end else begin
            lineIdx  <= lineIdx + LINE_W'(1);
            lineBase <= lineBase + BUF_AW'(STRIDE);
            state    <= S_FLAG_RD;
          end
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign rdEn   = ((state == S_FLAG_RD) && !allMode) || ((state == S_BYTE_PREP) && isData);
  assign rdAddr = (state == S_FLAG_RD) ? (lineBase + BUF_AW'(DIRTY_OFS))
                                       : (lineBase + dataOfs);
  assign strobe.load     = ((state == S_BYTE_PREP) && !isData) || (state == S_BYTE_WAIT);
  assign strobe.loadByte = (state == S_BYTE_WAIT) ? rdData : constByte;
  assign busy    = (state != S_IDLE);
  assign csOut   = csReg;
  assign doneIrq = (state == S_FINISH) && irqEnable;

  // R7: a command during an update leaves the selected mode untouched
  a_r7_cmd_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid) |=> $stable(allMode));

  // R8: the completion state is followed by idle
  a_r8_finish_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FINISH) |=> !busy);

  // R3: buffer reads only happen inside an update
  a_r3_read_in_update: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> csReg);

  // R6: chip select is low whenever the engine is idle
  a_r6_cs_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !csOut);

endmodule

// File: rtl/lcdline_top.sv
module lcdline_top
  import lcdline_pkg::*;
#(
  parameter int         NUM_LINES     = 536,
  parameter int         STRIDE        = 44,
  parameter int         DATA_BYTES    = 42,
  parameter int         DIRTY_OFS     = 42,
  parameter int         ADDR_BYTES    = 2,
  parameter int         TRAILER_BYTES = 2,
  parameter logic [7:0] MODE_BYTE     = 8'h80,
  parameter logic [7:0] DIV_RESET     = 8'd99,
  localparam int        BUF_AW        = $clog2(NUM_LINES * STRIDE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdBits,
  input  logic              presWr,
  input  logic [7:0]        presIn,
  input  logic              irqEnable,
  output logic              rdEn,
  output logic [BUF_AW-1:0] rdAddr,
  input  logic [7:0]        rdData,
  output logic              busy,
  output logic              doneIrq,
  output logic              lcdSclk,
  output logic              lcdMosi,
  output logic              lcdCs
);

  dpStrobe_t strobe;
  logic      byteDone;

  lcdline_ctrl #(
    .NUM_LINES(NUM_LINES), .STRIDE(STRIDE), .DATA_BYTES(DATA_BYTES),
    .DIRTY_OFS(DIRTY_OFS), .ADDR_BYTES(ADDR_BYTES),
    .TRAILER_BYTES(TRAILER_BYTES), .MODE_BYTE(MODE_BYTE), .BUF_AW(BUF_AW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdBits(cmdBits),
    .irqEnable(irqEnable), .rdData(rdData), .byteDone(byteDone),
    .rdEn(rdEn), .rdAddr(rdAddr), .strobe(strobe), .busy(busy),
    .csOut(lcdCs), .doneIrq(doneIrq)
  );

  lcdline_shift #(.DIV_RESET(DIV_RESET)) u_shift (
    .clk(clk), .rstN(rstN), .presWr(presWr), .presIn(presIn),
    .strobe(strobe), .sclk(lcdSclk), .mosi(lcdMosi), .byteDone(byteDone)
  );

  // R6: the serial clock is never active outside chip select
  a_r6_sclk_in_cs: assert property (@(posedge clk) disable iff (!rstN)
    !lcdCs |-> !lcdSclk);

endmodule

// File: tb/lcdline_top_bench.sv
module lcdline_top_bench;

  localparam int NL = 5, STR = 6, DB = 4, DOFS = 5, AB = 2, TB = 2;
  localparam logic [7:0] MODE = 8'h80;
  localparam int AW = $clog2(NL * STR);
  localparam int MAXB = 2048;

  logic clk = 0, rstN = 0, cmdValid = 0, presWr = 0, irqEnable = 1;
  logic [1:0] cmdBits = 0;
  logic [7:0] presIn = 0, rdData;
  logic rdEn, busy, doneIrq, lcdSclk, lcdMosi, lcdCs;
  logic [AW-1:0] rdAddr;

  logic [7:0] mem [0:NL*STR-1];
  logic capBits [0:MAXB-1];
  logic expBits [0:MAXB-1];
  int capN = 0, expN = 0, irqCnt = 0, csBad = 0, cyc = 0, t0 = 0, t1 = 0;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  lcdline_top #(.NUM_LINES(NL), .STRIDE(STR), .DATA_BYTES(DB), .DIRTY_OFS(DOFS),
    .ADDR_BYTES(AB), .TRAILER_BYTES(TB), .MODE_BYTE(MODE)) u_lcdline_top (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdBits(cmdBits),
    .presWr(presWr), .presIn(presIn), .irqEnable(irqEnable),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .busy(busy),
    .doneIrq(doneIrq), .lcdSclk(lcdSclk), .lcdMosi(lcdMosi), .lcdCs(lcdCs));

  always @(posedge clk) if (rdEn) rdData <= mem[rdAddr];

  always @(posedge lcdSclk) begin
    if (capN == 0) t0 = cyc;
    if (capN == 1) t1 = cyc;
    if (capN < MAXB) capBits[capN] = lcdMosi;
    if (!lcdCs) csBad++;
    capN++;
  end

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (doneIrq) irqCnt++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      finishRun();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic pushByte(input logic [7:0] b, input bit msbFirst);
    for (int i = 0; i < 8; i++) begin
      expBits[expN] = msbFirst ? b[7-i] : b[i];
      expN++;
    end
  endtask

  task automatic buildExpected(input bit allM);
    expN = 0;
    for (int ln = 0; ln < NL; ln++) begin
      if (allM || mem[ln*STR+DOFS][0]) begin
        logic [15:0] num;
        num = 16'(ln + 1);
        pushByte(MODE, 1);
        pushByte(num[15:8], 1);
        pushByte(num[7:0], 1);
        for (int d = 0; d < DB; d++) pushByte(mem[ln*STR+d], 0);
        for (int t = 0; t < TB; t++) pushByte(8'h00, 0);
      end
    end
  endtask

  task automatic compareStream(input string req);
    int firstBad;
    firstBad = -1;
    check(capN == expN, {req, " bit count"}, capN, expN);
    for (int i = 0; i < expN && i < capN; i++)
      if (firstBad < 0 && capBits[i] !== expBits[i]) firstBad = i;
    check(firstBad < 0, {req, " stream bit mismatch at index"}, firstBad, -1);
  endtask

  task automatic fillMem(input int dirtyMask);
    for (int a = 0; a < NL*STR; a++) mem[a] = 8'($urandom);
    for (int ln = 0; ln < NL; ln++)
      mem[ln*STR+DOFS] = {mem[ln*STR+DOFS][7:1], 1'(dirtyMask >> ln)};
  endtask

  task automatic setPres(input logic [7:0] v);
    @(negedge clk); presWr = 1; presIn = v;
    @(negedge clk); presWr = 0;
  endtask

  // issue a command and wait for the update to finish
  task automatic runCmd(input logic [1:0] bits, input int midCmdAt);
    int guard;
    capN = 0; irqCnt = 0; csBad = 0;
    @(negedge clk); cmdValid = 1; cmdBits = bits;
    @(negedge clk); cmdValid = 0;
    check(busy == 1, "R7 busy after command", busy, 1);
    check(lcdCs == 1, "R6 cs after command", lcdCs, 1);
    guard = 0;
    while (busy && guard < 40000) begin
      @(negedge clk);
      guard++;
      if (guard == midCmdAt) begin
        cmdValid = 1; cmdBits = 2'b10;
        @(negedge clk); cmdValid = 0; guard++;
      end
    end
    check(busy == 0 && lcdCs == 0, "R7 update ends idle", {busy, lcdCs}, 0);
    check(csBad == 0, "R6 sclk outside cs", csBad, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < NL*STR; a++) mem[a] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check({busy, lcdCs, lcdSclk, lcdMosi, doneIrq} == 5'b0, "R1 reset outputs",
          {busy, lcdCs, lcdSclk, lcdMosi, doneIrq}, 0);

    // R1/R5: default prescaler 99, one dirty line
    fillMem(5'b00100);
    buildExpected(0);
    runCmd(2'b01, -1);
    compareStream("R1 default-rate dirty update");
    check(t1 - t0 == 100, "R1 default bit period", t1 - t0, 100);
    check(irqCnt == 1, "R8 irq count", irqCnt, 1);

    // R10: empty command ignored
    @(negedge clk); cmdValid = 1; cmdBits = 2'b00;
    @(negedge clk); cmdValid = 0;
    repeat (3) @(negedge clk);
    check(busy == 0 && lcdCs == 0, "R10 zero command ignored", {busy, lcdCs}, 0);

    // R2/R4/R5: all-lines with P = 2
    setPres(8'd1);
    fillMem(5'b00000);
    buildExpected(1);
    runCmd(2'b10, -1);
    compareStream("R2 all-lines update");
    check(t1 - t0 == 2, "R5 bit period pres=1", t1 - t0, 2);
    check(irqCnt == 1, "R8 irq after all-lines", irqCnt, 1);

    // R2: both bits behave as all-lines
    fillMem(5'b01010);
    buildExpected(1);
    runCmd(2'b11, -1);
    compareStream("R2 both bits");

    // R3/R4: random dirty masks
    for (int it = 0; it < 4; it++) begin
      fillMem(int'($urandom % 32) | 1);
      buildExpected(0);
      runCmd(2'b01, -1);
      compareStream("R3 dirty-only random");
    end

    // R3: only last line dirty
    fillMem(5'b10000);
    buildExpected(0);
    runCmd(2'b01, -1);
    compareStream("R3 last line only");

    // R9: no dirty lines
    fillMem(5'b00000);
    runCmd(2'b01, -1);
    check(capN == 0, "R9 no serial clocks", capN, 0);
    check(irqCnt == 1, "R9 completion still fires", irqCnt, 1);

    // R7: command mid-update ignored
    fillMem(5'b00010);
    buildExpected(0);
    runCmd(2'b01, 30);
    compareStream("R7 mid-update command ignored");
    check(irqCnt == 1, "R7 single completion", irqCnt, 1);

    // R8: interrupt disabled
    irqEnable = 0;
    fillMem(5'b00001);
    runCmd(2'b01, -1);
    check(irqCnt == 0, "R8 irq masked", irqCnt, 0);
    irqEnable = 1;

    // R5: prescaler 0 acts as 1, prescaler 3 gives 4
    setPres(8'd0);
    fillMem(5'b00001);
    buildExpected(0);
    runCmd(2'b01, -1);
    compareStream("R5 pres=0 stream");
    check(t1 - t0 == 2, "R5 pres=0 period", t1 - t0, 2);
    setPres(8'd3);
    runCmd(2'b01, -1);
    compareStream("R5 pres=3 stream");
    check(t1 - t0 == 4, "R5 pres=3 period", t1 - t0, 4);

    finishRun();
  end

endmodule